// File: doc/BRIEF.md
# Supply Supervisor and Fault Recovery Controller

This block decides when an offline converter controller may switch and when its high-voltage startup source should charge the supply capacitor. It receives already-digitized comparator flags for the supply rail (turn-on level, turn-off level, power-down-reset level, overvoltage), for the error-amplifier voltage (overload level) and for the die temperature. From them it keeps a powered/unpowered state with hysteresis, drives the startup source enable and its current-level select, times a soft-start window after every turn-on, and produces the single switching enable for the cycle sequencer.

Three faults can hold switching off, each with its own release rule. An overload must persist for a programmed number of consecutive cycles before it latches. It is then released only after a fixed number of supply turn-off events, so the converter restarts in a slow hiccup. An overvoltage latches at once and holds until the next supply turn-on. Overtemperature simply follows its comparator flag, which carries the thermal hysteresis. A fall below the power-down-reset level wipes every latch and the hiccup count.

All times are parameters in clock cycles. Every output is a registered function of inputs sampled at the previous clock edge.

Top module: `supply_supervisor`

## Requirements
- R1: While unpowered, a sampled turn-on flag with the turn-off flag low makes the block powered from the next cycle. When both flags are sampled high together, the block stays unpowered.
- R2: While powered, a sampled turn-off flag makes the block unpowered from the next cycle.
- R3: `hv_src_en_o` is 1 exactly while the block is unpowered, and is 1 after reset.
- R4: `hv_src_hi_o` is 1 only while the startup source is enabled and the power-down-reset flag sampled at the previous edge was 0. It is 0 after reset.
- R5: `soft_start_o` is 1 for exactly SS_CYCLES cycles starting the cycle after a turn-on, and drops at once on turn-off.
- R6: The overload latch sets after `comp_ovl_i` has been sampled high on OLP_DELAY consecutive edges while powered. A single low sample restarts the count.
- R7: A set overload latch clears on the OLP_RESTARTS-th (4 by default) supply turn-off event counted after it was set.
- R8: A sampled `vcc_ovp_i` stops switching from the next cycle. Switching stays stopped until the next turn-on event, even after the flag goes low.
- R9: A sampled `temp_hot_i` stops switching on the next cycle, and clearing the flag allows switching again on the next cycle.
- R10: A sampled `vcc_pdr_i` clears the overload latch, the turn-off event count and the overvoltage latch.
- R11: `sw_en_o` is 1 exactly when powered and neither fault latch is set and the registered overtemperature flag is 0.
- R12: After reset the block is unpowered, and `sw_en_o` and `soft_start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_on_i | input | 1 | Supply is above the turn-on level |
| vcc_off_i | input | 1 | Supply is below the turn-off level |
| vcc_pdr_i | input | 1 | Supply is below the power-down-reset level |
| vcc_ovp_i | input | 1 | Supply is above the overvoltage level |
| comp_ovl_i | input | 1 | Error voltage is above the overload level |
| temp_hot_i | input | 1 | Overtemperature comparator output (with thermal hysteresis) |
| hv_src_en_o | output | 1 | Enable for the high-voltage startup current source |
| hv_src_hi_o | output | 1 | Startup current select: 1 high setting, 0 low setting |
| soft_start_o | output | 1 | Soft-start window active |
| sw_en_o | output | 1 | Switching enable to the cycle sequencer |

## Verification
The bench builds the block with OLP_DELAY of 20 cycles and SS_CYCLES of 10, keeping OLP_RESTARTS at 4. The real-time defaults run to millions of cycles. These reduced values let one run reach a full overload latch with its 19-versus-20 cycle boundary and the whole four-event hiccup release. They also fit the end of a soft-start window, a reset of the overload count by power-down in the middle of a hiccup, and the restart of the delay timer by a short overload pulse. A behavioural model in the bench is compared against all four outputs on every clock.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
// Shared types for the supply supervisor.
// Assumes: fault sources are independent single-bit conditions.
package sup_pkg;

    // Set of conditions that each hold switching off
    typedef struct packed {
        logic ovp;
        logic ovl;
        logic hot;
    } fault_set_t;

    // True when any fault blocks switching
    function automatic logic fault_blocks(input fault_set_t f);
        return f.ovp | f.ovl | f.hot;
    endfunction

endpackage

// File: rtl/sup_uvlo.sv
`timescale 1ns/1ps
// Powered-state tracker with hysteresis and startup source control.
// Assumes: the turn-on and turn-off flags come from separate comparators.
// When both are high together, turn-off wins.
module sup_uvlo (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_on_i,
    input  logic vcc_off_i,
    input  logic vcc_pdr_i,
    output logic powered_o,
    output logic on_evt_o,
    output logic off_evt_o,
    output logic hv_en_o,
    output logic hv_hi_o
);
    logic on_q;
    logic pdr_q;

    assign on_evt_o  = !on_q && vcc_on_i && !vcc_off_i;
    assign off_evt_o = on_q && vcc_off_i;

    // Powered state: turn-off has priority over turn-on
    always_ff @(posedge clk) begin
        if (!rst_n)          on_q <= 1'b0;
        else if (vcc_off_i)  on_q <= 1'b0;
        else if (vcc_on_i)   on_q <= 1'b1;
    end

    // Registered power-down-reset flag selecting the startup current level
    always_ff @(posedge clk) begin
        if (!rst_n) pdr_q <= 1'b1;
        else        pdr_q <= vcc_pdr_i;
    end

    assign powered_o = on_q;
    assign hv_en_o   = !on_q;
    assign hv_hi_o   = !on_q && !pdr_q;

    // R1
    turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!powered_o && vcc_on_i && !vcc_off_i) |=> powered_o);
    // R2
    turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_o && vcc_off_i) |=> !powered_o);
endmodule

// File: rtl/sup_ovl.sv
`timescale 1ns/1ps
// Overload qualification timer, overload latch and hiccup release counter.
// Assumes: the turn-off event is a one-cycle pulse from the powered tracker.
module sup_ovl #(
    parameter int DELAY    = 33_750_000,
    parameter int RESTARTS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered_i,
    input  logic comp_ovl_i,
    input  logic off_evt_i,
    input  logic pdr_i,
    output logic latch_o
);
    localparam int TW = $clog2(DELAY + 1);
    localparam int CW = $clog2(RESTARTS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(DELAY - 1);
    localparam logic [CW-1:0] C_LAST = CW'(RESTARTS - 1);

    logic [TW-1:0] tmr_q;
    logic [CW-1:0] evt_q;
    logic          latch_q;

    // Delay timer, latch set and release by counted turn-off events
    always_ff @(posedge clk) begin
        if (!rst_n || pdr_i) begin
            tmr_q   <= '0;
            evt_q   <= '0;
            latch_q <= 1'b0;
        end else if (latch_q) begin
            tmr_q <= '0;
            if (off_evt_i) begin
                if (evt_q == C_LAST) begin
                    evt_q   <= '0;
                    latch_q <= 1'b0;
                end else begin
                    evt_q <= evt_q + 1'b1;
                end
            end
        end else begin
            evt_q <= '0;
            if (powered_i && comp_ovl_i) begin
                if (tmr_q == T_LAST) begin
                    tmr_q   <= '0;
                    latch_q <= 1'b1;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end else begin
                tmr_q <= '0;
            end
        end
    end

    assign latch_o = latch_q;

    // R6
    ovl_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_o) |-> $past(comp_ovl_i && powered_i));
    // R7
    ovl_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_o) |-> $past(off_evt_i || pdr_i));
endmodule

// File: rtl/sup_softstart.sv
`timescale 1ns/1ps
// Soft-start window timer started by each turn-on event.
// Assumes: LEN fits the counter derived from it; LEN of 0 disables the window.
module sup_softstart #(
    parameter int LEN = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered_i,
    input  logic on_evt_i,
    input  logic off_evt_i,
    output logic active_o
);
    localparam int SW = $clog2(LEN + 1);
    localparam logic [SW-1:0] LOAD = SW'(LEN);

    logic [SW-1:0] cnt_q;

    // Load on turn-on, clear when unpowered, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (on_evt_i)               cnt_q <= LOAD;
        else if (off_evt_i || !powered_i) cnt_q <= '0;
        else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = powered_i && (cnt_q != '0);

    generate
        if (LEN > 0) begin : g_ss_chk
            // R5
            ss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
                on_evt_i |=> active_o);
        end
    endgenerate
    // R5
    ss_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_evt_i |=> !active_o);
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
// Power-state and protection controller: combines supply state, soft start
// and the three fault sources into the switching enable.
// Assumes: all inputs are synchronous digitized comparator flags.
module supply_supervisor #(
    parameter int OLP_DELAY    = 33_750_000,
    parameter int OLP_RESTARTS = 4,
    parameter int SS_CYCLES    = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_on_i,
    input  logic vcc_off_i,
    input  logic vcc_pdr_i,
    input  logic vcc_ovp_i,
    input  logic comp_ovl_i,
    input  logic temp_hot_i,
    output logic hv_src_en_o,
    output logic hv_src_hi_o,
    output logic soft_start_o,
    output logic sw_en_o
);
    import sup_pkg::*;

    logic       powered;
    logic       on_evt;
    logic       off_evt;
    logic       ovl_latch;
    logic       ovp_q;
    logic       hot_q;
    fault_set_t faults;

    sup_uvlo u_uvlo (
        .clk       (clk),
        .rst_n     (rst_n),
        .vcc_on_i  (vcc_on_i),
        .vcc_off_i (vcc_off_i),
        .vcc_pdr_i (vcc_pdr_i),
        .powered_o (powered),
        .on_evt_o  (on_evt),
        .off_evt_o (off_evt),
        .hv_en_o   (hv_src_en_o),
        .hv_hi_o   (hv_src_hi_o)
    );

    sup_ovl #(.DELAY(OLP_DELAY), .RESTARTS(OLP_RESTARTS)) u_ovl (
        .clk        (clk),
        .rst_n      (rst_n),
        .powered_i  (powered),
        .comp_ovl_i (comp_ovl_i),
        .off_evt_i  (off_evt),
        .pdr_i      (vcc_pdr_i),
        .latch_o    (ovl_latch)
    );

    sup_softstart #(.LEN(SS_CYCLES)) u_ss (
        .clk       (clk),
        .rst_n     (rst_n),
        .powered_i (powered),
        .on_evt_i  (on_evt),
        .off_evt_i (off_evt),
        .active_o  (soft_start_o)
    );

    // Overvoltage latch: set by the flag, cleared by turn-on or power-down reset
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovp_q <= 1'b0;
        else if (vcc_ovp_i)           ovp_q <= 1'b1;
        else if (vcc_pdr_i || on_evt) ovp_q <= 1'b0;
    end

    // Registered overtemperature flag
    always_ff @(posedge clk) begin
        if (!rst_n) hot_q <= 1'b0;
        else        hot_q <= temp_hot_i;
    end

    assign faults  = '{ovp: ovp_q, ovl: ovl_latch, hot: hot_q};
    assign sw_en_o = powered && !fault_blocks(faults);

    // R8
    ovp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_ovp_i |=> !sw_en_o);
    // R8
    ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en_o && ovp_q && !vcc_pdr_i && !on_evt) |=> !sw_en_o);
    // R9
    hot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot_i |=> !sw_en_o);
    // R3
    src_vs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_src_en_o && sw_en_o));
endmodule

// File: tb/supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_tb_top;
    localparam int DLY = 20;
    localparam int RST = 4;
    localparam int SS  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic von = 1'b0, voff = 1'b0, vpdr = 1'b1, vovp = 1'b0, comp = 1'b0, hot = 1'b0;
    logic hv_en, hv_hi, ss_o, sw_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_pw = 0, m_ovp = 0, m_ovl = 0, m_hot = 0, m_pdr = 1, m_tmr = 0, m_evt = 0, m_ss = 0;

    always #4 clk = ~clk;

    supply_supervisor #(.OLP_DELAY(DLY), .OLP_RESTARTS(RST), .SS_CYCLES(SS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vcc_on_i(von), .vcc_off_i(voff), .vcc_pdr_i(vpdr), .vcc_ovp_i(vovp),
        .comp_ovl_i(comp), .temp_hot_i(hot),
        .hv_src_en_o(hv_en), .hv_src_hi_o(hv_hi), .soft_start_o(ss_o), .sw_en_o(sw_o)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int on_e, off_e;
        if (!rst_n) begin
            m_pw = 0; m_ovp = 0; m_ovl = 0; m_hot = 0; m_pdr = 1; m_tmr = 0; m_evt = 0; m_ss = 0;
        end else begin
            on_e  = (m_pw == 0 && von && !voff);
            off_e = (m_pw == 1 && voff);
            if (vovp) m_ovp = 1; else if (vpdr || on_e) m_ovp = 0;
            if (vpdr) begin
                m_ovl = 0; m_evt = 0; m_tmr = 0;
            end else if (m_ovl) begin
                m_tmr = 0;
                if (off_e) begin
                    m_evt++;
                    if (m_evt == RST) begin m_ovl = 0; m_evt = 0; end
                end
            end else begin
                m_evt = 0;
                if (m_pw && comp) begin
                    m_tmr++;
                    if (m_tmr == DLY) begin m_ovl = 1; m_tmr = 0; end
                end else m_tmr = 0;
            end
            if (on_e) m_ss = SS; else if (off_e || !m_pw) m_ss = 0; else if (m_ss > 0) m_ss--;
            if (voff) m_pw = 0; else if (von) m_pw = 1;
            m_hot = hot;
            m_pdr = vpdr;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 hv_src_en", hv_en, m_pw == 0);
            chk("R4 hv_src_hi", hv_hi, m_pw == 0 && m_pdr == 0);
            chk("R5 soft_start", ss_o, m_pw == 1 && m_ss > 0);
            chk("R11 sw_en", sw_o, m_pw == 1 && !m_ovp && !m_ovl && !m_hot);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic pwr_up();   von = 1'b1;  tick(); von = 1'b0;  tick(); endtask
    task automatic pwr_down(); voff = 1'b1; tick(); voff = 1'b0; tick(); endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100_000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(4);
        // R12 reset state
        chk("R12 sw_en reset", sw_o, 1'b0);
        chk("R12 soft_start reset", ss_o, 1'b0);
        chk("R12 hv_en reset", hv_en, 1'b1);
        chk("R4 hv_hi reset", hv_hi, 1'b0);
        rst_n = 1'b1; tick();
        vpdr = 1'b0; tick();
        chk("R4 high current above pdr", hv_hi, 1'b1);
        // R1 simultaneous flags keep it off
        von = 1'b1; voff = 1'b1; tick(); von = 1'b0; voff = 1'b0; tick();
        chk("R1 both flags stays off", hv_en, 1'b1);
        // R1 turn-on and R5 soft-start length
        von = 1'b1; tick(); von = 1'b0;
        chk("R1 powered", hv_en, 1'b0);
        chk("R5 ss starts", ss_o, 1'b1);
        tick(SS - 1);
        chk("R5 ss last cycle", ss_o, 1'b1);
        tick();
        chk("R5 ss ended", ss_o, 1'b0);
        chk("R11 switching", sw_o, 1'b1);
        // R6 short pulse restarts timer
        comp = 1'b1; tick(DLY - 5); comp = 1'b0; tick();
        comp = 1'b1; tick(DLY - 1);
        chk("R6 not yet latched", sw_o, 1'b1);
        tick();
        chk("R6 latched", sw_o, 1'b0);
        comp = 1'b0;
        // R7 hiccup release after four turn-offs
        for (int k = 0; k < RST - 1; k++) begin
            pwr_down(); pwr_up();
            chk("R7 still latched", sw_o, 1'b0);
        end
        pwr_down(); pwr_up();
        chk("R7 released", sw_o, 1'b1);
        // R2 turn-off
        voff = 1'b1; tick(); voff = 1'b0;
        chk("R2 unpowered", hv_en, 1'b1);
        pwr_up();
        // R8 overvoltage hold until turn-on
        vovp = 1'b1; tick(); vovp = 1'b0;
        chk("R8 stop", sw_o, 1'b0);
        tick(5);
        chk("R8 hold", sw_o, 1'b0);
        pwr_down(); pwr_up();
        chk("R8 released at turn-on", sw_o, 1'b1);
        // R9 overtemperature
        hot = 1'b1; tick();
        chk("R9 hot stop", sw_o, 1'b0);
        hot = 1'b0; tick();
        chk("R9 cool resume", sw_o, 1'b1);
        // R10 pdr clears latch and the event count
        comp = 1'b1; tick(DLY); comp = 1'b0;
        chk("R6 latched again", sw_o, 1'b0);
        pwr_down(); pwr_up(); pwr_down();
        vpdr = 1'b1; tick(); vpdr = 1'b0; tick();
        pwr_up();
        chk("R10 latch cleared", sw_o, 1'b1);
        comp = 1'b1; tick(DLY); comp = 1'b0;
        for (int k = 0; k < RST - 1; k++) begin
            pwr_down(); pwr_up();
            chk("R10 count cleared", sw_o, 1'b0);
        end
        pwr_down(); pwr_up();
        chk("R10 full count needed", sw_o, 1'b1);
        // R10 pdr also clears overvoltage latch
        vovp = 1'b1; tick(); vovp = 1'b0; vpdr = 1'b1; tick(); vpdr = 1'b0; tick();
        chk("R10 ovp cleared by pdr", sw_o, 1'b1);
        tick(3);
        finish_run();
    end
endmodule